// File: doc/BRIEF.md
# Serial CRC Signature Analyzer

This block is the response compactor of a built-in self-test setup. A circuit under test emits one result bit per clock. The analyzer treats the accepted bits as the coefficients of a polynomial, highest order first, and divides it over GF(2) by x^5 + x^4 + x^2 + 1. Only the 5-bit remainder is kept. That remainder is the signature, so the chip does not need to store a full table of expected responses.

The divider is a shift register with XOR taps inside the chain. Each accepted bit enters the x^0 stage. The x^4 stage feeds back into the x^0, x^2 and x^4 positions. A synchronous clear starts a new stream. When the stream ends, the caller raises an end strobe. The block then compares the signature with a golden value supplied on an input and gives a one-cycle pass pulse or a one-cycle miscompare pulse.

Top module: `crc_sig_analyzer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `signature` is 0 and both `sig_ok` and `sig_bad` are low.
- R2: After a clear, the accepted stream 1,1,1,1,0,1,0,1 (first bit is the x^7 coefficient) leaves `signature` = 5'b10100. Bit i of `signature` is the x^i coefficient, so reading bit 0 up to bit 4 gives 0,0,1,0,1.
- R3: Take a cycle with `din_valid` high and `clear` low. After that clock edge, `signature` equals (old signature · x + `din`) mod (x^5 + x^4 + x^2 + 1).
- R4: A cycle with `din_valid` low and `clear` low leaves `signature` unchanged, whatever the value of `din`.
- R5: A cycle with `clear` high sets `signature` to 0 after that edge. This holds even when `din_valid` is high in the same cycle.
- R6: Take a cycle where `stream_end` is high. If `golden` equals the signature that this cycle produces, then in the next cycle `sig_ok` is high for exactly one cycle and `sig_bad` is low.
- R7: Take a cycle where `stream_end` is high. If `golden` differs from the signature that this cycle produces, then in the next cycle `sig_bad` is high for exactly one cycle and `sig_ok` is low.
- R8: The end strobe judges the signature as it stands after that same cycle's accepted bit or clear. A bit that arrives together with `stream_end` is therefore included in the comparison.
- R9: `sig_ok` and `sig_bad` are never high together. Both are low in any cycle that does not directly follow an end strobe.
- R10: After a clear, any stream that is an exact multiple of the divisor leaves `signature` = 0. Examples are 1,1,0,1,0,1 and 1,1,0,1,0,1,0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous signature clear, takes priority over data |
| din_valid | input | 1 | Qualifies `din` for this cycle |
| din | input | 1 | Serial response bit, highest-order coefficient first |
| stream_end | input | 1 | Requests a comparison against `golden` |
| golden | input | 5 | Expected signature |
| signature | output | 5 | Current remainder, bit i = x^i coefficient |
| sig_ok | output | 1 | One-cycle pulse: signature matched at end of stream |
| sig_bad | output | 1 | One-cycle pulse: signature differed at end of stream |

## Verification
Every output of this block is a register that takes its new value on the first clock edge after the input cycle that causes it. The signature reflects an accepted bit or a clear one edge later. The pass and miscompare pulses follow the end strobe by one edge. The driver applies one input cycle per clock at the falling edge and queues the outputs it expects after the next rising edge. The monitor samples 2 ns after that rising edge and compares all three outputs. Pulse lengths are therefore checked cycle by cycle, because every cycle that has no end strobe expects both flags low.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int SIG_W = 5;
  // divisor taps below the implicit top term: x^4, x^2, x^0
  localparam logic [SIG_W-1:0] DIV_TAPS = 5'b10101;

  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_OK   = 2'd1,
    VERDICT_BAD  = 2'd2
  } verdict_e;
endpackage

// File: rtl/sa_div_cell.sv
module sa_div_cell #(
  parameter bit TAP = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic shift_en,
  input  logic link_in,
  input  logic feedback,
  output logic q,
  output logic d
);
  always_comb begin
    if (clr)           d = 1'b0;
    else if (shift_en) d = link_in ^ (TAP & feedback);
    else               d = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/sa_divider.sv
module sa_divider #(
  parameter int              W    = sa_pkg::SIG_W,
  parameter logic [W-1:0]    TAPS = sa_pkg::DIV_TAPS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] rem_q,
  output logic [W-1:0] rem_d
);
  localparam int TOP = W - 1;

  logic         fb;
  logic [W-1:0] link;

  assign fb      = rem_q[TOP];
  assign link[0] = din;

  genvar i;
  generate
    for (i = 1; i < W; i++) begin : g_link
      assign link[i] = rem_q[i-1];
    end
    for (i = 0; i < W; i++) begin : g_cell
      sa_div_cell #(.TAP(TAPS[i])) u_cell (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .shift_en (shift_en),
        .link_in  (link[i]),
        .feedback (fb),
        .q        (rem_q[i]),
        .d        (rem_d[i])
      );
    end
  endgenerate

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !shift_en) |=> $stable(rem_q)); // R4

  AST_SHIFT_NO_FB: assert property (@(posedge clk) disable iff (rst)
    (!clr && shift_en && !rem_q[TOP]) |=> rem_q == {$past(rem_q[TOP-1:0]), $past(din)}); // R3
endmodule

// File: rtl/sa_verdict.sv
module sa_verdict #(
  parameter int W = sa_pkg::SIG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         judge,
  input  logic [W-1:0] candidate,
  input  logic [W-1:0] golden,
  output logic         ok,
  output logic         bad
);
  import sa_pkg::*;

  verdict_e v_d;

  always_comb begin
    if (!judge)                  v_d = VERDICT_NONE;
    else if (candidate == golden) v_d = VERDICT_OK;
    else                         v_d = VERDICT_BAD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ok  <= 1'b0;
      bad <= 1'b0;
    end else begin
      ok  <= (v_d == VERDICT_OK);
      bad <= (v_d == VERDICT_BAD);
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ok && bad)); // R9

  AST_QUIET_NO_END: assert property (@(posedge clk) disable iff (rst)
    !judge |=> (!ok && !bad)); // R9

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    judge |=> (ok != bad)); // R6
endmodule

// File: rtl/crc_sig_analyzer.sv
module crc_sig_analyzer #(
  parameter int           W    = sa_pkg::SIG_W,
  parameter logic [W-1:0] TAPS = sa_pkg::DIV_TAPS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         din_valid,
  input  logic         din,
  input  logic         stream_end,
  input  logic [W-1:0] golden,
  output logic [W-1:0] signature,
  output logic         sig_ok,
  output logic         sig_bad
);
  logic [W-1:0] rem_d;

  sa_divider #(.W(W), .TAPS(TAPS)) u_div (
    .clk      (clk),
    .rst      (rst),
    .clr      (clear),
    .shift_en (din_valid),
    .din      (din),
    .rem_q    (signature),
    .rem_d    (rem_d)
  );

  sa_verdict #(.W(W)) u_verdict (
    .clk       (clk),
    .rst       (rst),
    .judge     (stream_end),
    .candidate (rem_d),
    .golden    (golden),
    .ok        (sig_ok),
    .bad       (sig_bad)
  );

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> (signature == '0)); // R5

  AST_END_MATCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (stream_end && !clear && !din_valid && golden == signature) |=> sig_ok); // R6

  AST_END_MISS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (stream_end && !clear && !din_valid && golden != signature) |=> sig_bad); // R7
endmodule

// File: tb/tb_crc_sig_analyzer.sv
`timescale 1ns/1ps
module tb_crc_sig_analyzer;
  logic       clk = 1'b0;
  logic       rst, clear, din_valid, din, stream_end;
  logic [4:0] golden;
  logic [4:0] signature;
  logic       sig_ok, sig_bad;

  typedef struct {
    logic [4:0] sig;
    logic       ok;
    logic       bad;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         n_checks = 0;
  int         n_fails  = 0;
  logic [4:0] m_sig    = 5'd0;
  logic [31:0] rng     = 32'h1234_5678;

  always #5 clk = ~clk;

  crc_sig_analyzer dut (
    .clk(clk), .rst(rst), .clear(clear), .din_valid(din_valid), .din(din),
    .stream_end(stream_end), .golden(golden), .signature(signature),
    .sig_ok(sig_ok), .sig_bad(sig_bad)
  );

  // remainder arithmetic: multiply by x, add bit, reduce by x^5+x^4+x^2+1
  function automatic logic [4:0] mod_step(logic [4:0] r, logic b);
    logic [5:0] t;
    t = {r, b};
    if (t[5]) t = t ^ 6'b110101;
    return t[4:0];
  endfunction

  function automatic logic [31:0] xs(logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic step(input logic vld, input logic b, input logic clr_i,
                      input logic end_i, input logic [4:0] gold, input string tag);
    exp_t e;
    @(negedge clk);
    din_valid = vld; din = b; clear = clr_i; stream_end = end_i; golden = gold;
    if (clr_i)    m_sig = 5'd0;
    else if (vld) m_sig = mod_step(m_sig, b);
    e.sig = m_sig;
    e.ok  = end_i && (gold == m_sig);
    e.bad = end_i && (gold != m_sig);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic stream(input logic [63:0] bits, input int n, input logic end_last,
                        input logic [4:0] gold, input string tag);
    for (int k = n - 1; k >= 0; k--)
      step(1'b1, bits[k], 1'b0, (k == 0) && end_last, gold, (k == 0) ? tag : "R3");
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (signature !== e.sig || sig_ok !== e.ok || sig_bad !== e.bad) begin
          n_fails++;
          $display("FAIL %s: sig=%b ok=%b bad=%b expected sig=%b ok=%b bad=%b",
                   e.tag, signature, sig_ok, sig_bad, e.sig, e.ok, e.bad);
        end
      end
    end
  end

  // watchdog
  initial begin
    #2000000;
    n_fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; clear = 1'b0; din_valid = 1'b0; din = 1'b0; stream_end = 1'b0; golden = 5'd0;
    repeat (3) @(posedge clk);
    #2;
    n_checks++;
    if (signature !== 5'd0 || sig_ok !== 1'b0 || sig_bad !== 1'b0) begin
      n_fails++;
      $display("FAIL R1: sig=%b ok=%b bad=%b expected 00000 0 0", signature, sig_ok, sig_bad);
    end
    @(negedge clk);
    rst = 1'b0;
    step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "R1");

    // reference division, end strobe together with last bit (R2, R8)
    step(1'b0, 1'b0, 1'b1, 1'b0, 5'd0, "R5");
    stream(64'b11110101, 8, 1'b1, 5'b10100, "R2");
    // ignored bits while valid low (R4), flags drop (R9)
    step(1'b0, 1'b1, 1'b0, 1'b0, 5'd0, "R4");
    step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "R9");
    // separate end strobe on held value (R6)
    step(1'b0, 1'b1, 1'b0, 1'b1, 5'b10100, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "R9");
    // mismatch (R7)
    step(1'b0, 1'b0, 1'b0, 1'b1, 5'b00101, "R7");
    // clear dominates valid (R5)
    step(1'b1, 1'b1, 1'b1, 1'b0, 5'd0, "R5");
    // divisor multiples (R10)
    stream(64'b110101, 6, 1'b1, 5'd0, "R10");
    step(1'b0, 1'b0, 1'b1, 1'b0, 5'd0, "R5");
    stream(64'b1101010, 7, 1'b1, 5'd0, "R10");
    // end with clear same cycle judges zero (R8)
    stream(64'b1011, 4, 1'b0, 5'd0, "R3");
    step(1'b1, 1'b1, 1'b1, 1'b1, 5'd0, "R8");
    // reference stream with gaps, miscompare on last bit (R7, R4)
    for (int k = 7; k >= 0; k--) begin
      logic [7:0] ref_bits;
      ref_bits = 8'b11110101;
      step(1'b0, ~ref_bits[k], 1'b0, 1'b0, 5'd0, "R4");
      step(1'b1, ref_bits[k], 1'b0, k == 0, 5'b10101, (k == 0) ? "R7" : "R3");
    end
    step(1'b0, 1'b0, 1'b1, 1'b0, 5'd0, "R5");
    // long mixed traffic
    for (int c = 0; c < 400; c++) begin
      logic v, b, cl, en;
      logic [4:0] g;
      rng = xs(rng);
      v  = rng[0] | rng[1];
      b  = rng[2];
      cl = (rng[7:3] == 5'd0);
      en = (rng[11:8] == 4'd0);
      g  = rng[16] ? (cl ? 5'd0 : (v ? mod_step(m_sig, b) : m_sig)) : rng[21:17];
      step(v, b, cl, en, g, en ? "R6" : "R3");
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, 5'd0, "R9");
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule